// File: doc/BRIEF.md
# Programmable-Tick Line Deglitcher

This block cleans up one asynchronous, idle-high, single-wire bus line before it reaches a protocol decoder. The raw line is first brought into the system clock domain by a two-flop synchroniser. A small qualifier state machine then decides whether each level change is real. A change is accepted only if the new level stays put for a programmable span. That span is the product of a 3-bit delay setting, a fixed factor of three and the period of a selectable tick. The tick is derived from the system clock, which is assumed to be a 24 MHz crystal clock. With the defaults, tick select 0, 1, 2 and 3 give periods of 3, 24, 240 and 2400 clocks, which is 125 ns, 1 µs, 10 µs and 100 µs. A delay of 7 with the 1 µs tick is a typical setting.

The qualifier has three states. ST_STABLE means the filtered output matches the synchronised line. ST_CHECK means a differing level is being timed. ST_COMMIT is the single cycle before the output flips. The transitions are:

- STABLE→CHECK: the line differs and the delay is non-zero. This transition also restarts the tick timebase.
- STABLE→COMMIT: the line differs and the delay is zero.
- CHECK→STABLE: the line reverts before the span has elapsed. This discards the partial count.
- CHECK→COMMIT: the last required tick arrives while the line still differs.
- COMMIT→STABLE: always.

A rise or fall strobe marks the cycle in which the output changes. A software reset input holds the whole filter idle for as long as it is high.

Top module: `line_deglitch`

## Requirements
- R1: While rst_n is low, line_out is 1 and both rise_pulse and fall_pulse are 0.
- R2: With filt_delay = 0, the filter adds no span. A line_raw change that is set up before clock edge n appears on line_out at edge n+3.
- R3: The qualifying span is L = filt_delay × 3 × P clocks, where P is the tick period. A line_raw change that is set up before edge n and then held for more than L clocks appears on line_out at edge n+L+3.
- R4: A new line_raw level that lasts L clocks or fewer produces no change on line_out. One that lasts L+1 clocks is accepted.
- R5: If the line returns to the output level during timing, the count is discarded. A later change is timed from its own start.
- R6: tick_sel selects P. The codes 0, 1, 2 and 3 give 3, 24, 240 and 2400 clocks.
- R7: rise_pulse is high for exactly the one cycle in which line_out goes from 0 to 1, and fall_pulse likewise for 1 to 0. The two strobes are never high together, and neither is high in any other cycle except as stated in R8.
- R8: While soft_rst is high, line_out goes to 1 at the next edge, both strobes stay 0 and any timing in progress is dropped. After soft_rst is released, a level held on line_raw is qualified from scratch, as if it had just changed at the release.
- R9: An accepted change that reverts immediately is requalified once the output has settled. If line_raw is set low before edge n, held for exactly L+1 clocks and then returned high, line_out falls at edge n+L+3 and rises at edge n+2L+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (crystal reference) |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous hold-in-reset, active high |
| line_raw | input | 1 | Unsynchronised bus line |
| tick_sel | input | 2 | Tick period select |
| filt_delay | input | 3 | Span multiplier; 0 disables filtering |
| line_out | output | 1 | Filtered line level |
| rise_pulse | output | 1 | One-cycle strobe on a 0-to-1 output change |
| fall_pulse | output | 1 | One-cycle strobe on a 1-to-0 output change |

## Verification
Long steps at every tick select confirm each period and the exact output latency, so a wrong divider ratio or an extra register shows up as a cycle mismatch. Pulses of exactly L and L+1 clocks bracket the acceptance threshold. The L+1 pulse that snaps straight back also exercises requalification after a commit. A short low, brief high, then low again pattern tells a restarting counter apart from one that keeps counting across a revert. A soft reset issued while the output is low, with the line still low, shows both the forced idle level and the fresh qualification after release.

// File: rtl/dg_pkg.sv
package dg_pkg;

    // Qualifier states
    typedef enum logic [1:0] {
        ST_STABLE = 2'd0,
        ST_CHECK  = 2'd1,
        ST_COMMIT = 2'd2
    } qual_state_t;

    // Bus idle level, used for reset and soft reset
    localparam logic IDLE_LEVEL = 1'b1;

    // Fixed multiplier applied to delay x tick
    localparam int SPAN_FACTOR = 3;

endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else if (clr) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dg_timebase.sv
module dg_timebase #(
    parameter int BASE_DIV  = 3,
    parameter int US_RATIO  = 8,
    parameter int DEC_RATIO = 10,
    parameter int SELW      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [SELW-1:0] sel,
    output logic            tick
);

    localparam int NSTG = 1 << SELW;
    localparam int BW   = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam int RMAX = (US_RATIO > DEC_RATIO) ? US_RATIO : DEC_RATIO;
    localparam int CW   = (RMAX > 1) ? $clog2(RMAX) : 1;

    logic [BW-1:0]   base_cnt;
    logic [NSTG-1:0] tk;

    // First stage: divide the crystal clock by BASE_DIV
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt <= '0;
        end else if (restart) begin
            base_cnt <= '0;
        end else if (base_cnt == BW'(BASE_DIV - 1)) begin
            base_cnt <= '0;
        end else begin
            base_cnt <= base_cnt + 1'b1;
        end
    end

    assign tk[0] = (base_cnt == BW'(BASE_DIV - 1));

    // Cascaded decimators; stage 1 gives microseconds, later stages decades
    for (genvar i = 1; i < NSTG; i++) begin : g_stage
        localparam int RATIO = (i == 1) ? US_RATIO : DEC_RATIO;
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (restart) begin
                cnt <= '0;
            end else if (tk[i-1]) begin
                if (cnt == CW'(RATIO - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign tk[i] = tk[i-1] && (cnt == CW'(RATIO - 1));
    end

    assign tick = tk[sel];

endmodule

// File: rtl/dg_qualifier.sv
module dg_qualifier
    import dg_pkg::*;
#(
    parameter int DW   = 3,
    parameter int CNTW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          sync_lvl,
    input  logic          tick,
    input  logic [DW-1:0] delay,
    output logic          line_out,
    output logic          rise_pulse,
    output logic          fall_pulse,
    output logic          tb_restart
);

    qual_state_t     state_q;
    qual_state_t     state_d;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] need;
    logic            out_q;

    assign need = CNTW'(delay) * CNTW'(SPAN_FACTOR);

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        tb_restart = 1'b0;
        unique case (state_q)
            ST_STABLE: begin
                if (sync_lvl != out_q) begin
                    if (delay == '0) begin
                        state_d = ST_COMMIT;
                    end else begin
                        state_d    = ST_CHECK;
                        tb_restart = 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (sync_lvl == out_q) begin
                    state_d = ST_STABLE;
                end else if (tick && (cnt_q == need - 1'b1)) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                state_d = ST_STABLE;
            end
            default: begin
                state_d = ST_STABLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else if (soft_rst) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Tick counter, live only while timing a candidate level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (soft_rst || (state_q != ST_CHECK)) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output register and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q      <= IDLE_LEVEL;
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end else if (soft_rst) begin
            out_q      <= IDLE_LEVEL;
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end else begin
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
            if (state_q == ST_COMMIT) begin
                out_q      <= ~out_q;
                rise_pulse <= ~out_q;
                fall_pulse <= out_q;
            end
        end
    end

    assign line_out = out_q;

endmodule

// File: rtl/line_deglitch.sv
module line_deglitch
    import dg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_DIV    = 3,
    parameter int US_RATIO    = 8,
    parameter int DEC_RATIO   = 10,
    parameter int SELW        = 2,
    parameter int DW          = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            line_raw,
    input  logic [SELW-1:0] tick_sel,
    input  logic [DW-1:0]   filt_delay,
    output logic            line_out,
    output logic            rise_pulse,
    output logic            fall_pulse
);

    localparam int MAX_NEED = ((1 << DW) - 1) * SPAN_FACTOR;
    localparam int CNTW     = $clog2(MAX_NEED + 1);

    logic sync_lvl;
    logic tick;
    logic tb_restart;

    dg_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LEVEL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .d     (line_raw),
        .q     (sync_lvl)
    );

    dg_timebase #(
        .BASE_DIV  (BASE_DIV),
        .US_RATIO  (US_RATIO),
        .DEC_RATIO (DEC_RATIO),
        .SELW      (SELW)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tb_restart || soft_rst),
        .sel     (tick_sel),
        .tick    (tick)
    );

    dg_qualifier #(
        .DW   (DW),
        .CNTW (CNTW)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .sync_lvl   (sync_lvl),
        .tick       (tick),
        .delay      (filt_delay),
        .line_out   (line_out),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse),
        .tb_restart (tb_restart)
    );

endmodule

// File: rtl/dg_checker.sv
module dg_checker (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic line_out,
    input logic rise_pulse,
    input logic fall_pulse
);

    AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (line_out && !rise_pulse && !fall_pulse)); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse && fall_pulse)); // R7

    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> (line_out && !$past(line_out))); // R7

    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> (!line_out && $past(line_out))); // R7

    AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_out != $past(line_out)) && !$past(soft_rst)) |-> (rise_pulse || fall_pulse)); // R7

endmodule

bind line_deglitch dg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .line_out   (line_out),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse)
);

// File: tb/sim_line_deglitch.sv
module sim_line_deglitch;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       soft_rst;
    logic       line_raw;
    logic [1:0] tick_sel;
    logic [2:0] filt_delay;
    logic       line_out;
    logic       rise_pulse;
    logic       fall_pulse;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_errors = 0;
    bit  started = 1'b0;
    bit  done = 1'b0;
    logic prev_out = 1'b1;

    typedef struct {
        int    at;
        logic  lvl;
        bit    strobe;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_item;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    line_deglitch u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .line_raw   (line_raw),
        .tick_sel   (tick_sel),
        .filt_delay (filt_delay),
        .line_out   (line_out),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input int at, input logic lvl, input bit strobe, input string tag);
        exp_t e;
        e.at = at; e.lvl = lvl; e.strobe = strobe; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Drive a level at a falling edge and hold it; optionally predict the output change
    task automatic apply(input logic lvl, input int hold, input bit expect_chg,
                         input int span, input string tag);
        line_raw = lvl;
        if (expect_chg) push_exp(cyc + span + 4, lvl, 1'b1, tag);
        repeat (hold) @(negedge clk);
    endtask

    // Monitor: pops one expected item for every output change
    always @(negedge clk) begin
        if (started && rst_n) begin
            if (line_out !== prev_out) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected output change, level", int'(line_out), int'(prev_out));
                end else begin
                    mon_item = exp_q.pop_front();
                    chk(line_out === mon_item.lvl, mon_item.tag, "output level",
                        int'(line_out), int'(mon_item.lvl));
                    chk(cyc == mon_item.at, mon_item.tag, "output change cycle",
                        cyc, mon_item.at);
                    if (mon_item.strobe)
                        chk((rise_pulse === line_out) && (fall_pulse === ~line_out), "R7",
                            "strobe pair {rise,fall}", int'({rise_pulse, fall_pulse}),
                            int'({line_out, ~line_out}));
                    else
                        chk(!rise_pulse && !fall_pulse, "R8", "strobes during soft reset",
                            int'({rise_pulse, fall_pulse}), 0);
                end
            end else if (rise_pulse || fall_pulse) begin
                chk(1'b0, "R7", "strobe without output change", int'({rise_pulse, fall_pulse}), 0);
            end
            prev_out = line_out;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R3", "watchdog expired, cycles", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int c0;
        int r;
        rst_n = 1'b0; soft_rst = 1'b0; line_raw = 1'b1; tick_sel = 2'd0; filt_delay = 3'd0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(line_out === 1'b1, "R1", "line_out in reset", int'(line_out), 1);
        chk(rise_pulse === 1'b0, "R1", "rise_pulse in reset", int'(rise_pulse), 0);
        chk(fall_pulse === 1'b0, "R1", "fall_pulse in reset", int'(fall_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        started = 1'b1;
        prev_out = line_out;

        // R2: no filtering with delay 0
        apply(1'b0, 20, 1'b1, 0, "R2");
        apply(1'b1, 20, 1'b1, 0, "R2");

        // R3: sel 0, delay 1 -> L = 9
        filt_delay = 3'd1;
        apply(1'b0, 30, 1'b1, 9, "R3");
        apply(1'b1, 30, 1'b1, 9, "R3");

        // R4: sel 0, delay 7 -> L = 63; exactly L rejected
        filt_delay = 3'd7;
        apply(1'b0, 63, 1'b0, 63, "R4");
        apply(1'b1, 80, 1'b0, 63, "R4");
        chk(line_out === 1'b1, "R4", "output after L-clock glitch", int'(line_out), 1);

        // R9: L+1 accepted, then immediate return is requalified
        c0 = cyc;
        push_exp(c0 + 63 + 4, 1'b0, 1'b1, "R4");
        push_exp(c0 + 2 * 63 + 6, 1'b1, 1'b1, "R9");
        apply(1'b0, 64, 1'b0, 63, "R4");
        apply(1'b1, 200, 1'b0, 63, "R9");

        // R5: revert restarts the count
        apply(1'b0, 50, 1'b0, 63, "R5");
        apply(1'b1, 5, 1'b0, 63, "R5");
        apply(1'b0, 100, 1'b1, 63, "R5");
        chk(line_out === 1'b0, "R5", "output after restarted qualification", int'(line_out), 0);
        apply(1'b1, 100, 1'b1, 63, "R5");

        // R6: each tick select
        tick_sel = 2'd1; filt_delay = 3'd7;          // L = 504
        apply(1'b0, 600, 1'b1, 504, "R6");
        apply(1'b1, 600, 1'b1, 504, "R6");
        tick_sel = 2'd2; filt_delay = 3'd1;          // L = 720
        apply(1'b0, 800, 1'b1, 720, "R6");
        apply(1'b1, 800, 1'b1, 720, "R6");
        tick_sel = 2'd2; filt_delay = 3'd2;          // L = 1440, glitch of 1440 rejected
        apply(1'b0, 1440, 1'b0, 1440, "R6");
        apply(1'b1, 200, 1'b0, 1440, "R6");
        chk(line_out === 1'b1, "R6", "output after 10us-tick glitch", int'(line_out), 1);
        tick_sel = 2'd3; filt_delay = 3'd1;          // L = 7200
        apply(1'b0, 7300, 1'b1, 7200, "R6");
        apply(1'b1, 7300, 1'b1, 7200, "R6");

        // R8: soft reset forces idle, then requalifies the held level
        tick_sel = 2'd0; filt_delay = 3'd1;          // L = 9
        apply(1'b0, 30, 1'b1, 9, "R3");
        soft_rst = 1'b1;
        push_exp(cyc + 1, 1'b1, 1'b0, "R8");
        repeat (6) @(negedge clk);
        soft_rst = 1'b0;
        r = cyc;
        push_exp(r + 9 + 4, 1'b0, 1'b1, "R8");
        repeat (30) @(negedge clk);
        apply(1'b1, 30, 1'b1, 9, "R8");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "expected changes never seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule